// File: doc/BRIEF.md
# Serial Link Timeout Counter

This block measures time or traffic on one direction of a serial port and raises a sticky timeout flag when a programmed condition is met. It listens to three strobes from the serial engine beside it. `char_done` pulses once per completed character. `line_idle` is a level that is high while the line is quiet. `bit_tick` pulses once per bit period. One instance serves the receive side and another serves the transmit side.

A 2-bit condition select picks what is counted. The first choice counts characters. The second counts bit ticks of idle line. The third counts bit ticks of idle line, but only after a character has completed. The fourth measures the length of an idle gap and accepts it only if it falls inside a window. The lower bound of that window is the 16-bit timeout value and the upper bound is a separate extended value. Software clears the flag by pulsing `flag_clr`.

Top module: `tmo_counter`

## Requirements
- R1: After reset `timeout_flag` is 0.
- R2: Condition code 0 (characters): each `char_done` pulse adds one to the count. The pulse that brings the count to `cfg_limit` sets the flag on the next clock edge and returns the count to 0.
- R3: Condition code 1 (idle): each `bit_tick` seen while `line_idle` is 1 adds one to the count. The tick that brings the count to `cfg_limit` sets the flag. This happens only once per idle stretch.
- R4: Condition code 2 (after character): idle ticks are counted only once a `char_done` pulse has armed the counter. The arming pulse itself adds nothing. Reaching `cfg_limit` sets the flag and disarms the counter until the next `char_done`.
- R5: In condition codes 1, 2 and 3, a `char_done` pulse or `line_idle` at 0 returns the count to 0.
- R6: Condition code 3 (window): when `line_idle` falls from 1 to 0, the flag is set if the number of idle ticks in that stretch was strictly greater than `cfg_limit` and strictly less than `cfg_ext_limit`. Otherwise the flag is left as it is.
- R7: In condition code 3, a `cfg_ext_limit` of 0 disables the window, and the flag is never set.
- R8: The flag stays at 1 until a cycle with `flag_clr` at 1. If a set event and `flag_clr` occur in the same cycle, the set wins.
- R9: While `cfg_en` is 0 the count is held at 0, no event is raised, and the flag keeps its value. Counting restarts from 0 once the counter is enabled again.
- R10: A `cfg_limit` of 0 never sets the flag, in any condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Counter enable |
| cfg_cond | input | 2 | Condition select: 0 characters, 1 idle, 2 after character, 3 window |
| cfg_limit | input | CNT_W | Timeout value (characters or bit ticks) |
| cfg_ext_limit | input | CNT_W | Upper bound of the idle window for condition 3; 0 disables it |
| char_done | input | 1 | One-cycle pulse per completed character |
| line_idle | input | 1 | High while the line is idle |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| flag_clr | input | 1 | Write-one clear of the flag |
| timeout_flag | output | 1 | Sticky timeout flag |

## Verification
The hardest case to reach from the ports is the window condition. In that mode the decision is taken only at the falling edge of `line_idle`, so an idle gap must be built with an exact tick count before the line goes busy. The stimulus drives gaps just below, at and just above both window bounds. A behavioural model predicts the flag on every clock. Enable is also toggled in the middle of a count, to show that counting restarts from zero while an earlier flag survives.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  typedef enum logic [1:0] {
    COND_CHARS     = 2'd0,
    COND_IDLE      = 2'd1,
    COND_POST_CHAR = 2'd2,
    COND_WINDOW    = 2'd3
  } tmo_cond_e;
endpackage

// File: rtl/tmo_edges.sv
module tmo_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic line_idle,
  input  logic char_done,
  input  logic bit_tick,
  output logic idle_end,
  output logic restart,
  output logic idle_tick
);
  logic idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= line_idle;
  end

  // idle stretch finishes when the line turns busy
  assign idle_end  = idle_q & ~line_idle;
  assign restart   = char_done | ~line_idle;
  assign idle_tick = bit_tick & line_idle;
endmodule

// File: rtl/tmo_core.sv
module tmo_core
  import tmo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  tmo_cond_e        cond,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] ext_limit,
  input  logic             char_done,
  input  logic             idle_tick,
  input  logic             restart,
  input  logic             idle_end,
  output logic             fire,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  function automatic logic at_max(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return at_max(v) ? v : v + 1'b1;
  endfunction

  function automatic logic inside_window(input logic [CNT_W-1:0] v,
                                         input logic [CNT_W-1:0] lo,
                                         input logic [CNT_W-1:0] hi);
    return (hi != ZERO) && (lo != ZERO) && (v > lo) && (v < hi);
  endfunction

  logic             armed, armed_n;
  logic [CNT_W-1:0] cnt_n, bumped;
  logic             hits;

  assign bumped = bump(count);
  assign hits   = (limit != ZERO) && !at_max(count) && (bumped == limit);

  always_comb begin
    cnt_n   = count;
    armed_n = armed;
    fire    = 1'b0;
    if (!en) begin
      cnt_n   = ZERO;
      armed_n = 1'b0;
    end else begin
      case (cond)
        COND_CHARS: begin
          if (char_done) begin
            if (hits) begin
              fire  = 1'b1;
              cnt_n = ZERO;
            end else begin
              cnt_n = bumped;
            end
          end
        end
        COND_IDLE: begin
          if (restart) cnt_n = ZERO;
          else if (idle_tick) begin
            cnt_n = bumped;
            fire  = hits;
          end
        end
        COND_POST_CHAR: begin
          if (char_done) begin
            cnt_n   = ZERO;
            armed_n = 1'b1;
          end else if (restart) begin
            cnt_n = ZERO;
          end else if (idle_tick && armed) begin
            if (hits) begin
              fire    = 1'b1;
              armed_n = 1'b0;
              cnt_n   = ZERO;
            end else begin
              cnt_n = bumped;
            end
          end
        end
        default: begin
          fire = idle_end && inside_window(count, limit, ext_limit);
          if (restart) cnt_n = ZERO;
          else if (idle_tick) cnt_n = bumped;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= ZERO;
      armed <= 1'b0;
    end else begin
      count <= cnt_n;
      armed <= armed_n;
    end
  end
endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter
  import tmo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_cond,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic [CNT_W-1:0] cfg_ext_limit,
  input  logic             char_done,
  input  logic             line_idle,
  input  logic             bit_tick,
  input  logic             flag_clr,
  output logic             timeout_flag
);
  logic             idle_end_w, restart_w, idle_tick_w, fire_w;
  logic [CNT_W-1:0] count_w;
  tmo_cond_e        cond_w;

  assign cond_w = tmo_cond_e'(cfg_cond);

  tmo_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_idle (line_idle),
    .char_done (char_done),
    .bit_tick  (bit_tick),
    .idle_end  (idle_end_w),
    .restart   (restart_w),
    .idle_tick (idle_tick_w)
  );

  tmo_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .cond      (cond_w),
    .limit     (cfg_limit),
    .ext_limit (cfg_ext_limit),
    .char_done (char_done),
    .idle_tick (idle_tick_w),
    .restart   (restart_w),
    .idle_end  (idle_end_w),
    .fire      (fire_w),
    .count     (count_w)
  );

  tmo_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (fire_w),
    .clr    (flag_clr),
    .flag   (timeout_flag)
  );
endmodule

// File: rtl/tmo_counter_chk.sv
module tmo_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic [1:0]       cfg_cond,
  input logic [CNT_W-1:0] cfg_limit,
  input logic [CNT_W-1:0] cfg_ext_limit,
  input logic             flag_clr,
  input logic             timeout_flag,
  input logic             fire,
  input logic [CNT_W-1:0] count,
  input logic             idle_end
);
  p_fire_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> timeout_flag);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fire) |=> !timeout_flag);
  p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(fire));
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !fire);
  p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (count == '0));
  p_zero_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_limit == '0) |-> !fire);
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_cond == 2'd3) |-> (idle_end && count > cfg_limit && count < cfg_ext_limit));
  p_ext_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cond == 2'd3 && cfg_ext_limit == '0) |-> !fire);
  p_chars_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_cond == 2'd0 && cfg_en) |=> (count == '0));
endmodule

bind tmo_counter tmo_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .cfg_cond      (cfg_cond),
  .cfg_limit     (cfg_limit),
  .cfg_ext_limit (cfg_ext_limit),
  .flag_clr      (flag_clr),
  .timeout_flag  (timeout_flag),
  .fire          (fire_w),
  .count         (count_w),
  .idle_end      (idle_end_w)
);

// File: tb/tb_tmo_counter.sv
module tb_tmo_counter;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic [1:0] cfg_cond = 2'd0;
  logic [15:0] cfg_limit = 16'd0;
  logic [15:0] cfg_ext_limit = 16'd0;
  logic char_done = 1'b0, line_idle = 1'b0, bit_tick = 1'b0, flag_clr = 1'b0;
  logic timeout_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmo_counter dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cond(cfg_cond),
    .cfg_limit(cfg_limit), .cfg_ext_limit(cfg_ext_limit),
    .char_done(char_done), .line_idle(line_idle), .bit_tick(bit_tick),
    .flag_clr(flag_clr), .timeout_flag(timeout_flag)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference
  int m_cnt = 0, m_armed = 0, m_idle_q = 0, m_flag = 0;

  always @(posedge clk or negedge rst_n) begin : ref_model
    int ev;
    int lim, ext;
    ev = 0;
    lim = int'(cfg_limit);
    ext = int'(cfg_ext_limit);
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_idle_q = 0; m_flag = 0;
    end else begin
      if (!cfg_en) begin
        m_cnt = 0; m_armed = 0;
      end else if (cfg_cond == 2'd0) begin
        if (char_done) begin
          if (lim != 0 && m_cnt + 1 == lim) begin ev = 1; m_cnt = 0; end
          else if (m_cnt < MAXV) m_cnt++;
        end
      end else if (cfg_cond == 2'd1) begin
        if (char_done || !line_idle) m_cnt = 0;
        else if (bit_tick && m_cnt < MAXV) begin
          m_cnt++;
          if (lim != 0 && m_cnt == lim) ev = 1;
        end
      end else if (cfg_cond == 2'd2) begin
        if (char_done) begin m_cnt = 0; m_armed = 1; end
        else if (!line_idle) m_cnt = 0;
        else if (bit_tick && m_armed == 1 && m_cnt < MAXV) begin
          m_cnt++;
          if (lim != 0 && m_cnt == lim) begin ev = 1; m_armed = 0; m_cnt = 0; end
        end
      end else begin
        if (m_idle_q == 1 && !line_idle && lim != 0 && ext != 0 && m_cnt > lim && m_cnt < ext)
          ev = 1;
        if (char_done || !line_idle) m_cnt = 0;
        else if (bit_tick && m_cnt < MAXV) m_cnt++;
      end
      m_idle_q = line_idle ? 1 : 0;
      if (ev == 1) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: timeout_flag=%0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle, then compare with the model after the edge
  task automatic run(input logic cd, input logic idle, input logic tk, input logic clr);
    char_done = cd; line_idle = idle; bit_tick = tk; flag_clr = clr;
    @(negedge clk);
    check(tag, int'(timeout_flag), m_flag);
  endtask

  task automatic expect_flag(input string req, input int exp);
    check(req, int'(timeout_flag), exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) run(1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic setup(input logic en, input logic [1:0] c, input int lim, input int ext);
    cfg_en = 1'b0;
    run(1'b0, 1'b0, 1'b0, 1'b1);
    cfg_en = en; cfg_cond = c;
    cfg_limit = 16'(lim); cfg_ext_limit = 16'(ext);
    run(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic window_gap(input int n, input int exp, input string req);
    ticks(n);
    run(1'b0, 1'b0, 1'b0, 1'b0);
    expect_flag(req, exp);
    run(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: timeout_flag=%0d expected run end", timeout_flag);
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    tag = "R1";
    expect_flag("R1", 0);
    rst_n = 1'b1;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    expect_flag("R1", 0);

    // R2 character count
    tag = "R2";
    setup(1'b1, 2'd0, 3, 0);
    run(1'b1, 1'b0, 1'b0, 1'b0);
    run(1'b1, 1'b0, 1'b0, 1'b0);
    expect_flag("R2", 0);
    run(1'b1, 1'b0, 1'b0, 1'b0);
    expect_flag("R2", 1);
    tag = "R8";
    run(1'b0, 1'b0, 1'b0, 1'b0);
    expect_flag("R8", 1);
    run(1'b0, 1'b0, 1'b0, 1'b1);
    expect_flag("R8", 0);
    tag = "R2";
    run(1'b1, 1'b0, 1'b0, 1'b0);
    run(1'b1, 1'b0, 1'b0, 1'b0);
    expect_flag("R2", 0);
    run(1'b1, 1'b0, 1'b0, 1'b0);
    expect_flag("R2", 1);

    // R3 idle ticks
    tag = "R3";
    setup(1'b1, 2'd1, 5, 0);
    ticks(4);
    expect_flag("R3", 0);
    ticks(1);
    expect_flag("R3", 1);
    run(1'b0, 1'b1, 1'b0, 1'b1);
    ticks(10);
    expect_flag("R3", 0);

    // R5 restart on character and on busy line
    tag = "R5";
    setup(1'b1, 2'd1, 5, 0);
    ticks(4);
    run(1'b1, 1'b1, 1'b1, 1'b0);
    ticks(4);
    expect_flag("R5", 0);
    ticks(1);
    expect_flag("R5", 1);
    setup(1'b1, 2'd1, 5, 0);
    ticks(4);
    run(1'b0, 1'b0, 1'b1, 1'b0);
    ticks(4);
    expect_flag("R5", 0);
    ticks(1);
    expect_flag("R5", 1);

    // R4 after-character
    tag = "R4";
    setup(1'b1, 2'd2, 3, 0);
    ticks(10);
    expect_flag("R4", 0);
    run(1'b1, 1'b1, 1'b1, 1'b0);
    ticks(2);
    expect_flag("R4", 0);
    ticks(1);
    expect_flag("R4", 1);
    run(1'b0, 1'b1, 1'b0, 1'b1);
    ticks(6);
    expect_flag("R4", 0);

    // R6 window bounds: limit 4, ext 10
    tag = "R6";
    setup(1'b1, 2'd3, 4, 10);
    window_gap(6, 1, "R6");
    window_gap(3, 0, "R6");
    window_gap(4, 0, "R6");
    window_gap(5, 1, "R6");
    window_gap(9, 1, "R6");
    window_gap(10, 0, "R6");
    window_gap(12, 0, "R6");
    ticks(6);
    expect_flag("R6", 0);

    // R7 extended value zero
    tag = "R7";
    setup(1'b1, 2'd3, 4, 0);
    window_gap(6, 0, "R7");

    // R8 set beats clear
    tag = "R8";
    setup(1'b1, 2'd0, 1, 0);
    run(1'b1, 1'b0, 1'b0, 1'b1);
    expect_flag("R8", 1);

    // R9 disable
    tag = "R9";
    setup(1'b1, 2'd1, 5, 0);
    ticks(5);
    expect_flag("R9", 1);
    cfg_en = 1'b0;
    ticks(2);
    expect_flag("R9", 1);
    run(1'b0, 1'b1, 1'b1, 1'b1);
    cfg_en = 1'b1;
    ticks(3);
    cfg_en = 1'b0;
    ticks(1);
    cfg_en = 1'b1;
    ticks(4);
    expect_flag("R9", 0);
    ticks(1);
    expect_flag("R9", 1);

    // R10 zero limit
    tag = "R10";
    setup(1'b1, 2'd0, 0, 0);
    for (int i = 0; i < 5; i++) run(1'b1, 1'b0, 1'b0, 1'b0);
    expect_flag("R10", 0);
    setup(1'b1, 2'd1, 0, 0);
    ticks(20);
    expect_flag("R10", 0);
    setup(1'b1, 2'd3, 0, 10);
    window_gap(5, 0, "R10");

    finish_run();
  end
endmodule